// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from reset until the memory is ready for normal use. It holds command inhibit until the clock is reported stable. It then drives NOP for the long power-up wait and precharges every bank. Two auto-refresh commands follow, and then it writes the mode register. A short settling wait comes last, after which it raises a done flag. A later controller takes over the bus once done is high.

Every wait is counted in clock cycles. The count is derived from a clock-frequency parameter (MHz) and a duration in nanoseconds, rounded up. The settling time after the mode write is given directly in cycles. The mode word from the input is cleaned before it is driven: the reserved bits are cleared, and an unsupported CAS latency code is replaced.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the bus shows command inhibit (`cs_n`=1) and `done` is 0.
- R2: After reset, while `clk_ok` is low, the block keeps command inhibit and issues nothing else.
- R3: Once `clk_ok` is seen high, NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1) is driven for exactly ceil(T_PWR_NS*CLK_MHZ/1000) cycles, and the precharge follows in the next cycle. If `clk_ok` drops during this wait, the bus returns to inhibit and the whole wait restarts when `clk_ok` comes back.
- R4: Precharge is encoded `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, with `addr[10]`=1 (all banks) and `ba`=0.
- R5: The only commands issued are, in this order: one precharge, auto refresh (0,0,0,1), a second auto refresh, and load mode register (0,0,0,0). No other command appears, and `ba` stays 0 throughout.
- R6: Between the precharge and the first refresh, NOP is driven for ceil(T_RP_NS*CLK_MHZ/1000) cycles.
- R7: Each refresh is followed by ceil(T_RC_NS*CLK_MHZ/1000) NOP cycles before the next command.
- R8: During load mode register, `addr[9:0]` carries the mode word with bits 11:10 forced to 0. The fields are: burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4, operating mode in bits 8:7, and write-burst mode in bit 9.
- R9: A CAS latency field other than 2 or 3 is replaced by 3 (3'b011) in the word that is loaded.
- R10: `done` rises after T_MRD_CYC NOP cycles that follow the mode load. It stays high, with NOP on the bus, until reset.
- R11: Once the precharge has been issued, `clk_ok` no longer affects the sequence or its timing.
- R12: A wait duration that is not a whole number of cycles is rounded up (66 ns at 100 MHz gives 7 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_ok | input | 1 | Clock reported stable |
| mode_word | input | 12 | Requested mode register value |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address lines |
| done | output | 1 | Initialization complete, sticky |

## Verification
The assertions assume that `rst` is asserted from time zero and held for at least one clock edge. They also assume that `mode_word` is a known value whenever the mode load happens. The bench drives `rst` high before the first edge and sets `mode_word` before each reset release. It changes inputs only on falling edges. It toggles `clk_ok` both inside and outside the power-up wait, so that both the restart path and the ignore path are exercised.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_INH = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdr_cmd_t CMD_LMR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    typedef enum logic [3:0] {
        ST_IDLE, ST_PWR, ST_PRE, ST_WRP, ST_REF1, ST_WRC1,
        ST_REF2, ST_WRC2, ST_LMR, ST_WMR, ST_DONE
    } init_state_t;

    localparam int MODE_W = 12;
    localparam int PRE_ALL_BIT = 10;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_mode_fix.sv
module sdram_mode_fix
    import sdram_init_pkg::*;
(
    input  logic [MODE_W-1:0] mode_in,
    output logic [MODE_W-1:0] mode_out
);
    logic [MODE_W-1:0] masked;
    logic [2:0]        lat;

    always_comb begin
        masked = mode_in & {2'b00, {(MODE_W-2){1'b1}}};
        lat    = masked[6:4];
        if (lat != 3'd2 && lat != 3'd3)
            lat = 3'd3;
        mode_out = {masked[MODE_W-1:7], lat, masked[3:0]};
    end
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 100,
    parameter int unsigned T_PWR_NS  = 100000,
    parameter int unsigned T_RP_NS   = 20,
    parameter int unsigned T_RC_NS   = 66,
    parameter int unsigned T_MRD_CYC = 2,
    parameter int          ADDR_W    = 12,
    parameter int          BA_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_ok,
    input  logic [11:0]       mode_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam int unsigned PWR_CYC = ns_to_cyc(T_PWR_NS, CLK_MHZ);
    localparam int unsigned RP_CYC  = ns_to_cyc(T_RP_NS, CLK_MHZ);
    localparam int unsigned RC_CYC  = ns_to_cyc(T_RC_NS, CLK_MHZ);
    localparam int unsigned MRD_CYC = (T_MRD_CYC == 0) ? 1 : T_MRD_CYC;
    localparam int unsigned MAX_CYC = max2(max2(PWR_CYC, RP_CYC), max2(RC_CYC, MRD_CYC));
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);

    init_state_t      state_q, state_d;
    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic [MODE_W-1:0] mode_clean;
    sdr_cmd_t         cmd;

    sdram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sdram_mode_fix u_mode (
        .mode_in  (mode_word),
        .mode_out (mode_clean)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (clk_ok) state_d = ST_PWR;
            ST_PWR:  if (!clk_ok) state_d = ST_IDLE;
                     else if (tmr_exp) state_d = ST_PRE;
            ST_PRE:  state_d = ST_WRP;
            ST_WRP:  if (tmr_exp) state_d = ST_REF1;
            ST_REF1: state_d = ST_WRC1;
            ST_WRC1: if (tmr_exp) state_d = ST_REF2;
            ST_REF2: state_d = ST_WRC2;
            ST_WRC2: if (tmr_exp) state_d = ST_LMR;
            ST_LMR:  state_d = ST_WMR;
            ST_WMR:  if (tmr_exp) state_d = ST_DONE;
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            ST_PWR:           tmr_val = CNT_W'(PWR_CYC - 1);
            ST_WRP:           tmr_val = CNT_W'(RP_CYC - 1);
            ST_WRC1, ST_WRC2: tmr_val = CNT_W'(RC_CYC - 1);
            ST_WMR:           tmr_val = CNT_W'(MRD_CYC - 1);
            default:          tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        addr = '0;
        case (state_q)
            ST_IDLE:          cmd = CMD_INH;
            ST_PRE: begin
                cmd               = CMD_PRE;
                addr[PRE_ALL_BIT] = 1'b1;
            end
            ST_REF1, ST_REF2: cmd = CMD_REF;
            ST_LMR: begin
                cmd              = CMD_LMR;
                addr[MODE_W-1:0] = mode_clean;
            end
            default:          cmd = CMD_NOP;
        endcase
    end

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign ba    = '0;
    assign done  = (state_q == ST_DONE);
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_ok,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);
    sdr_cmd_t c;
    logic [1:0] refs_q;

    assign c = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

    always_ff @(posedge clk) begin
        if (rst)
            refs_q <= '0;
        else if (c == CMD_REF && refs_q != 2'd3)
            refs_q <= refs_q + 1'b1;
    end

    p_reset_inhibit_r1: assert property (@(posedge clk) rst |=> (cs_n && !done));

    p_hold_inhibit_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !clk_ok) |=> cs_n);

    p_pre_all_r4: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_PRE) |-> (addr[PRE_ALL_BIT] && ba == '0));

    p_legal_cmd_r5: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_INH || c == CMD_NOP || c == CMD_PRE || c == CMD_REF || c == CMD_LMR) && ba == '0);

    p_nop_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_NOP || c == CMD_INH) |-> addr == '0);

    p_lmr_after_refs_r5: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_LMR) |-> refs_q == 2'd2);

    p_lmr_resv_r8: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_LMR) |-> addr[ADDR_W-1:10] == '0);

    p_lmr_cl_r9: assert property (@(posedge clk) disable iff (rst)
        (c == CMD_LMR) |-> (addr[6:4] == 3'd2 || addr[6:4] == 3'd3));

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_done_nop_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (c == CMD_NOP));

    p_done_after_lmr_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> refs_q == 2'd2);
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .clk_ok (clk_ok),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .ba     (ba),
    .addr   (addr),
    .done   (done)
);

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int EXP_PWR = 200;
    localparam int EXP_RP  = 2;
    localparam int EXP_RC  = 7;
    localparam int EXP_MRD = 2;
    localparam logic [3:0] C_INH = 4'b1111;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_LMR = 4'b0000;
    localparam int NVEC = 7;
    // {requested mode word, expected loaded word}
    localparam logic [23:0] VEC [NVEC] = '{
        {12'h022, 12'h022}, {12'h037, 12'h037}, {12'hC32, 12'h032},
        {12'h012, 12'h032}, {12'h3F8, 12'h3B8}, {12'hFFF, 12'h3BF},
        {12'h000, 12'h030}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_ok = 1'b0;
    logic [11:0] mode_word = '0;
    logic cs_n, ras_n, cas_n, we_n, done;
    logic [1:0] ba;
    logic [11:0] addr;
    int checks = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_pwrup_seq #(
        .CLK_MHZ(100), .T_PWR_NS(2000), .T_RP_NS(20), .T_RC_NS(66), .T_MRD_CYC(2)
    ) u_sdram_pwrup_seq (
        .clk(clk), .rst(rst), .clk_ok(clk_ok), .mode_word(mode_word),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .done(done)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_seq(input logic [11:0] mode, input logic [11:0] exp_a, input int drop_kind);
        int n = 0, t_nop = -1, t_pre = -1, t_r1 = -1, t_r2 = -1, t_lmr = -1, t_done = -1;
        int extra = 0, nref = 0;
        logic [3:0] c, prev;
        logic [11:0] lmr_a = '0;
        logic pre_a10 = 1'b0;
        prev = C_INH;
        mode_word = mode;
        clk_ok = 1'b1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        while (t_done < 0 && n < 2000) begin
            @(negedge clk);
            n++;
            c = {cs_n, ras_n, cas_n, we_n};
            if (c == C_NOP && prev == C_INH) t_nop = n;
            else if (c == C_PRE) begin t_pre = n; pre_a10 = addr[10]; end
            else if (c == C_REF) begin
                if (nref == 0) t_r1 = n; else t_r2 = n;
                nref++;
                if (drop_kind == 2) clk_ok = 1'b0;
            end
            else if (c == C_LMR) begin t_lmr = n; lmr_a = addr; end
            else if (c != C_NOP && c != C_INH) extra++;
            if (ba != 2'b00) extra++;
            if (done) t_done = n;
            if (drop_kind == 1 && n == 102) chk(c == C_INH, "R3 drop->inhibit", int'(c), int'(C_INH));
            if (drop_kind == 1 && n == 100) clk_ok = 1'b0;
            if (drop_kind == 1 && n == 104) clk_ok = 1'b1;
            prev = c;
        end
        chk(t_pre - t_nop == EXP_PWR, "R3 power wait", t_pre - t_nop, EXP_PWR);
        chk(pre_a10 == 1'b1, "R4 precharge all", int'(pre_a10), 1);
        chk(t_r1 - t_pre == EXP_RP + 1, "R6 tRP gap", t_r1 - t_pre, EXP_RP + 1);
        chk(t_r2 - t_r1 == EXP_RC + 1, "R7 R12 tRC gap 1", t_r2 - t_r1, EXP_RC + 1);
        chk(t_lmr - t_r2 == EXP_RC + 1, "R7 tRC gap 2", t_lmr - t_r2, EXP_RC + 1);
        chk(lmr_a == exp_a, "R8 R9 mode word", int'(lmr_a), int'(exp_a));
        chk(t_done - t_lmr == EXP_MRD + 1, "R10 tMRD then done", t_done - t_lmr, EXP_MRD + 1);
        chk(extra == 0 && nref == 2, "R5 command set", extra * 16 + nref, 2);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("  test done: total=%0d bad=%0d", checks, bad);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(cs_n == 1'b1 && done == 1'b0, "R1 reset state", {cs_n, done}, 2'b10);

        // vector table: full sequences with various mode words (R3..R10, R12)
        for (int i = 0; i < NVEC; i++)
            run_seq(VEC[i][23:12], VEC[i][11:0], 0);

        // R2: clock not yet stable keeps inhibit
        begin
            int held = 1;
            clk_ok = 1'b0;
            rst = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            rst = 1'b0;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (!(cs_n && !done)) held = 0;
            end
            chk(held == 1, "R2 inhibit while clk_ok low", held, 1);
        end

        // R3: clk_ok drop during the power wait restarts it
        run_seq(12'h022, 12'h022, 1);

        // R11: clk_ok drop after precharge is ignored
        run_seq(12'h033, 12'h033, 2);

        // R10: done stays high with NOP
        begin
            int stuck = 1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!(done && {cs_n, ras_n, cas_n, we_n} == C_NOP)) stuck = 0;
            end
            chk(stuck == 1, "R10 done sticky", stuck, 1);
        end

        // R1: reset clears done
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(cs_n == 1'b1 && done == 1'b0, "R1 reset after done", {cs_n, done}, 2'b10);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule